// File: doc/BRIEF.md
# Traffic Light Phase Sequencer

This block is the timing core of a road traffic light. While enabled it steps a single lamp set through green, yellow and red, holding each colour for a number of clock cycles taken from a packed 32-bit duration word. Two such words are supplied. A profile input chooses between them, so software can hold, for example, a rush-hour plan and a quiet-hours plan, and switch between them at any time. Two override modes replace the normal cycle with a flashing yellow or a flashing red lamp.

The block takes its control bits and both duration words from an external register file, which already holds them in flops. It returns a 2-bit colour code that software reads as status, and three lamp drives, of which at most one is lit at any time.

The phase machine has six states. HALT is entered from any state when the enable is low. RUN_RED is entered from HALT, or from either blink state, when enable is high and no blink bit is set. RUN_RED moves to RUN_GREEN when its time is up. RUN_GREEN moves to RUN_YELLOW when its time is up. RUN_YELLOW moves back to RUN_RED when its time is up. BLINK_RED is entered from any state while enabled with the flash-red bit set. BLINK_YEL is entered from any state while enabled with only the flash-yellow bit set.

When the register file is reset, its duration words take the values 0xCAFE1234 (word A) and 0xFACE5678 (word B), and all of its control bits are cleared. These two reset values are published in the package.

Top module: `traffic_phase_seq`

## Requirements
- R1: `state_code` is 00 for red, 01 for green and 10 for yellow. `lamp` bit 0 drives red, bit 1 drives yellow and bit 2 drives green, and at most one lamp bit is high.
- R2: While `rst_n` or `run_en` is low, the block sits in HALT one clock edge later, shows a steady red lamp with code 00, and keeps its phase counter cleared.
- R3: On the first clock edge that sees `run_en` high, with no blink bit set, the block enters red, and the full red duration starts.
- R4: Normal sequencing runs red, then green, then yellow, then red again, with no other order.
- R5: In the selected word, bits 19:8 give the red time, bits 31:20 give the green time and bits 7:0 give the yellow time. Each time is counted in clock cycles.
- R6: A programmed time of zero makes its phase last exactly one cycle.
- R7: When `profile_sel` is 0, word `plan_a` sets the times. When it is 1, word `plan_b` sets the times.
- R8: A change of `profile_sel` or of a word has no effect on the phase in progress. The phase keeps the duration it loaded on entry, and the new setting applies from the next phase entry.
- R9: While enabled with only `blink_yel` set, the code reads 10. The yellow lamp is lit for the first BLINK_HALF cycles and dark for the next BLINK_HALF cycles, repeating. Red and green stay dark.
- R10: While enabled with `blink_red` set, whatever the state of `blink_yel`, the code reads 00 and only the red lamp flashes, with the same BLINK_HALF on/off rhythm.
- R11: When the blink bits are cleared while enable stays high, sequencing resumes from red with a full red duration.
- R12: The blink bits have no effect while `run_en` is low, and the red lamp stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Sequencer enable |
| blink_yel | input | 1 | Flashing-yellow override |
| blink_red | input | 1 | Flashing-red override; wins over flashing yellow |
| profile_sel | input | 1 | Chooses `plan_b` (1) or `plan_a` (0) |
| plan_a | input | 32 | Duration word A: green 31:20, red 19:8, yellow 7:0 |
| plan_b | input | 32 | Duration word B, same layout |
| state_code | output | 2 | Current colour code for the status register |
| lamp | output | 3 | Lamp drives: bit 0 red, bit 1 yellow, bit 2 green |

## Verification
The bench sweeps every combination of red, green and yellow times drawn from {0,1,2,5}. It predicts the colour in every cycle from the sums of the effective durations, so a design that swapped two fields, kept a zero-time phase for zero or two cycles, or loaded one cycle long would mismatch in the first period. It also runs both reset-value words for a full period. It flips the profile in the middle of red, which catches a design that reloads the running phase. It checks flashing in both colours, blink-red priority, blink bits given while disabled, and the return to a full red phase after a blink. A design that began the flash dark, flashed the wrong colour, or resumed from mid-sequence would fail these checks.

// File: rtl/tl_seq_pkg.sv
package tl_seq_pkg;

    // Layout of one packed duration word
    localparam int WORD_W  = 32;
    localparam int YEL_LSB = 0;
    localparam int YEL_W   = 8;
    localparam int RED_LSB = 8;
    localparam int RED_W   = 12;
    localparam int GRN_LSB = 20;
    localparam int GRN_W   = 12;
    localparam int CNT_W   = (GRN_W > RED_W) ? ((GRN_W > YEL_W) ? GRN_W : YEL_W)
                                             : ((RED_W > YEL_W) ? RED_W : YEL_W);

    // Reset contents of the duration words held in the register file
    localparam logic [WORD_W-1:0] PLAN_A_RST = 32'hCAFE_1234;
    localparam logic [WORD_W-1:0] PLAN_B_RST = 32'hFACE_5678;

    // Status codes
    localparam logic [1:0] CODE_RED    = 2'b00;
    localparam logic [1:0] CODE_GREEN  = 2'b01;
    localparam logic [1:0] CODE_YELLOW = 2'b10;

    // Lamp bit positions
    localparam int LAMP_RED = 0;
    localparam int LAMP_YEL = 1;
    localparam int LAMP_GRN = 2;
    localparam int LAMP_N   = 3;

    typedef enum logic [2:0] {
        PH_HALT,
        PH_RUN_RED,
        PH_RUN_GREEN,
        PH_RUN_YELLOW,
        PH_BLINK_RED,
        PH_BLINK_YEL
    } phase_e;

endpackage

// File: rtl/tl_dur_pick.sv
module tl_dur_pick
    import tl_seq_pkg::*;
(
    input  logic [WORD_W-1:0] plan_a,
    input  logic [WORD_W-1:0] plan_b,
    input  logic              sel_b,
    input  phase_e            target,
    output logic [CNT_W-1:0]  dur
);
    logic [WORD_W-1:0] word;

    assign word = sel_b ? plan_b : plan_a;

    always_comb begin
        unique case (target)
            PH_RUN_GREEN:  dur = CNT_W'(word[GRN_LSB +: GRN_W]);
            PH_RUN_YELLOW: dur = CNT_W'(word[YEL_LSB +: YEL_W]);
            default:       dur = CNT_W'(word[RED_LSB +: RED_W]);
        endcase
    end
endmodule

// File: rtl/tl_phase_timer.sv
module tl_phase_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - ONE;
    end

    // A loaded value of 0 or 1 both end the phase after one cycle
    assign expire = (cnt <= ONE);

    AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && cnt == '0) |=> (cnt == '0)); // R6
endmodule

// File: rtl/tl_blink_gen.sv
module tl_blink_gen #(
    parameter int HALF = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic lit
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
            lit <= 1'b1;
        end else if (cnt == LAST) begin
            cnt <= '0;
            lit <= ~lit;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    AST_BLINK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R9
    AST_BLINK_START_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> lit); // R9
endmodule

// File: rtl/traffic_phase_seq.sv
module traffic_phase_seq
    import tl_seq_pkg::*;
#(
    parameter int BLINK_HALF = 25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              blink_yel,
    input  logic              blink_red,
    input  logic              profile_sel,
    input  logic [WORD_W-1:0] plan_a,
    input  logic [WORD_W-1:0] plan_b,
    output logic [1:0]        state_code,
    output logic [LAMP_N-1:0] lamp
);
    phase_e            ph_q, ph_d, load_tgt;
    logic              load, clr, expire, blinking, lit;
    logic [CNT_W-1:0]  dur, cnt;

    tl_dur_pick u_pick (
        .plan_a (plan_a),
        .plan_b (plan_b),
        .sel_b  (profile_sel),
        .target (load_tgt),
        .dur    (dur)
    );

    tl_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (load),
        .load_val (dur),
        .cnt      (cnt),
        .expire   (expire)
    );

    assign blinking = (ph_q == PH_BLINK_RED) || (ph_q == PH_BLINK_YEL);

    tl_blink_gen #(.HALF(BLINK_HALF)) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (blinking),
        .lit    (lit)
    );

    // Next phase and timer load
    always_comb begin
        ph_d     = ph_q;
        load     = 1'b0;
        load_tgt = PH_RUN_RED;
        if (!run_en) begin
            ph_d = PH_HALT;
        end else if (blink_red) begin
            ph_d = PH_BLINK_RED;
        end else if (blink_yel) begin
            ph_d = PH_BLINK_YEL;
        end else begin
            unique case (ph_q)
                PH_HALT, PH_BLINK_RED, PH_BLINK_YEL: begin
                    ph_d     = PH_RUN_RED;
                    load     = 1'b1;
                    load_tgt = PH_RUN_RED;
                end
                PH_RUN_RED: if (expire) begin
                    ph_d     = PH_RUN_GREEN;
                    load     = 1'b1;
                    load_tgt = PH_RUN_GREEN;
                end
                PH_RUN_GREEN: if (expire) begin
                    ph_d     = PH_RUN_YELLOW;
                    load     = 1'b1;
                    load_tgt = PH_RUN_YELLOW;
                end
                PH_RUN_YELLOW: if (expire) begin
                    ph_d     = PH_RUN_RED;
                    load     = 1'b1;
                    load_tgt = PH_RUN_RED;
                end
                default: ph_d = PH_HALT;
            endcase
        end
    end

    assign clr = (ph_d == PH_HALT) || (ph_d == PH_BLINK_RED) || (ph_d == PH_BLINK_YEL);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_HALT;
        else        ph_q <= ph_d;
    end

    // Outputs
    always_comb begin
        state_code = CODE_RED;
        lamp       = '0;
        unique case (ph_q)
            PH_HALT, PH_RUN_RED: begin
                state_code     = CODE_RED;
                lamp[LAMP_RED] = 1'b1;
            end
            PH_RUN_GREEN: begin
                state_code     = CODE_GREEN;
                lamp[LAMP_GRN] = 1'b1;
            end
            PH_RUN_YELLOW: begin
                state_code     = CODE_YELLOW;
                lamp[LAMP_YEL] = 1'b1;
            end
            PH_BLINK_RED: begin
                state_code     = CODE_RED;
                lamp[LAMP_RED] = lit;
            end
            PH_BLINK_YEL: begin
                state_code     = CODE_YELLOW;
                lamp[LAMP_YEL] = lit;
            end
            default: begin
                state_code = CODE_RED;
                lamp       = '0;
            end
        endcase
    end

    AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lamp)); // R1
    AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_code == CODE_RED && lamp == 3'b001)); // R2
    AST_RED_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && blink_red) |=> (state_code == CODE_RED && !lamp[LAMP_YEL] && !lamp[LAMP_GRN])); // R10
    AST_GREEN_TO_YELLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RUN_GREEN && cnt <= CNT_W'(1) && run_en && !blink_red && !blink_yel)
        |=> (state_code == CODE_YELLOW)); // R4
    AST_RESUME_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (blinking && run_en && !blink_red && !blink_yel) |=> (lamp == 3'b001 && !blinking)); // R11
endmodule

// File: tb/test_traffic_phase_seq.sv
module test_traffic_phase_seq;
    import tl_seq_pkg::*;

    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        blink_yel = 1'b0;
    logic        blink_red = 1'b0;
    logic        profile_sel = 1'b0;
    logic [31:0] plan_a = '0;
    logic [31:0] plan_b = '0;
    logic [1:0]  state_code;
    logic [2:0]  lamp;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    traffic_phase_seq #(.BLINK_HALF(HALF)) i_traffic_phase_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .blink_yel(blink_yel),
        .blink_red(blink_red), .profile_sel(profile_sel), .plan_a(plan_a),
        .plan_b(plan_b), .state_code(state_code), .lamp(lamp)
    );

    function automatic logic [31:0] pack(int g, int r, int y);
        return {12'(g), 12'(r), 8'(y)};
    endfunction

    function automatic int eff(int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic logic [1:0] exp_code(int r, int g, int y, int k);
        int m;
        m = k % (eff(r) + eff(g) + eff(y));
        if (m < eff(r)) return 2'b00;
        if (m < eff(r) + eff(g)) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic [2:0] lamp_of(logic [1:0] c);
        return (c == 2'b01) ? 3'b100 : (c == 2'b10) ? 3'b010 : 3'b001;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_seq(string req, int r, int g, int y, int k);
        logic [1:0] c;
        c = exp_code(r, g, y, k);
        chk(req, "code", 32'(state_code), 32'(c));
        chk(req, "lamp", 32'(lamp), 32'(lamp_of(c)));
    endtask

    task automatic chk_halt(string req);
        chk(req, "halt code", 32'(state_code), 32'(2'b00));
        chk(req, "halt lamp", 32'(lamp), 32'(3'b001));
    endtask

    // Enable with given words, follow n cycles, then disable
    task automatic run_plan(logic [31:0] a, logic [31:0] b, logic p,
                            int r, int g, int y, int n, string req);
        plan_a = a; plan_b = b; profile_sel = p; run_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk_seq(req, r, g, y, k);
        end
        run_en = 1'b0;
        @(negedge clk);
        chk_halt("R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int vals[4] = '{0, 1, 2, 5};
        int r, g, y, p;
        logic [31:0] used, other;

        // R2: reset state
        repeat (3) begin
            @(negedge clk);
            chk_halt("R2");
        end
        rst_n = 1'b1;

        // R12: blink bits ignored while disabled
        blink_red = 1'b1; blink_yel = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk_halt("R12");
        end
        blink_red = 1'b0; blink_yel = 1'b0;

        // R3 R4 R5 R6 R7: sweep of durations and profile
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int l = 0; l < 4; l++) begin
                    r = vals[i]; g = vals[j]; y = vals[l];
                    p = (i + j + l) % 2;
                    used  = pack(g, r, y);
                    other = pack(7 + j, 9 + l, 3 + i);
                    run_plan(p ? other : used, p ? used : other, 1'(p), r, g, y,
                             2 * (eff(r) + eff(g) + eff(y)) + 1, "R5");
                end

        // R5 R7: reset-value words, one period each
        run_plan(PLAN_A_RST, PLAN_B_RST, 1'b0, 'hE12, 'hCAF, 'h34,
                 'hE12 + 'hCAF + 'h34 + 2, "R5");
        run_plan(PLAN_A_RST, PLAN_B_RST, 1'b1, 'hE56, 'hFAC, 'h78,
                 'hE56 + 'hFAC + 'h78 + 2, "R7");

        // R8: profile flip during red
        plan_a = pack(3, 5, 2); plan_b = pack(6, 2, 4); profile_sel = 1'b0; run_en = 1'b1;
        for (int k = 0; k < 18; k++) begin
            logic [1:0] c;
            @(negedge clk);
            c = (k < 5) ? 2'b00 : (k < 11) ? 2'b01 : (k < 15) ? 2'b10 : (k < 17) ? 2'b00 : 2'b01;
            chk("R8", "code", 32'(state_code), 32'(c));
            if (k == 1) profile_sel = 1'b1;
        end
        run_en = 1'b0;
        @(negedge clk);
        profile_sel = 1'b0;

        // R9: flashing yellow entered mid-sequence
        plan_a = pack(4, 5, 3); run_en = 1'b1;
        repeat (7) @(negedge clk);
        blink_yel = 1'b1;
        for (int jj = 0; jj < 12; jj++) begin
            @(negedge clk);
            chk("R9", "code", 32'(state_code), 32'(2'b10));
            chk("R9", "lamp", 32'(lamp), ((jj / HALF) % 2 == 0) ? 32'h2 : 32'h0);
        end

        // R10: red wins when both are set
        blink_red = 1'b1;
        for (int jj = 0; jj < 6; jj++) begin
            @(negedge clk);
            chk("R10", "code", 32'(state_code), 32'(2'b00));
            chk("R10", "no yel/grn", 32'(lamp[2:1]), 32'(0));
        end

        // R11: resume from a full red phase
        blink_red = 1'b0; blink_yel = 1'b0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            chk_seq("R11", 5, 4, 3, k);
        end

        // R10: flashing red alone, from the start of the flash
        blink_red = 1'b1;
        for (int jj = 0; jj < 12; jj++) begin
            @(negedge clk);
            chk("R10", "lamp", 32'(lamp), ((jj / HALF) % 2 == 0) ? 32'h1 : 32'h0);
        end

        // R2 R12: disable during flash gives steady red
        run_en = 1'b0;
        repeat (8) begin
            @(negedge clk);
            chk_halt("R12");
        end
        blink_red = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule